// File: doc/BRIEF.md
# Register-Bank Access Error Monitor

This block sits in front of a small memory-mapped control bank and checks every bus access. It serves the bank's own control words (status, interrupt enables, fault capture and the unlock keys) and watches for two kinds of misuse. The first is a write to a guarded word while the bank is locked. The second is any access whose word address falls outside the decoded map. Each misuse sets a raw status flag. Each flag has its own enable bit, and the flags are routed to a read-error line, a write-error line and one combined error line.

The first misuse after a re-arm is recorded. The block captures its word address, a two-bit kind code and the requester's sideband (an ID and a privilege bit). The capture is held until software writes the fault-clear bit, so later faults cannot hide the original cause. The bank powers up locked. Software opens it by writing two key words to two key registers in order, and any later write to either key register closes it again.

The bus accepts one request per cycle once reset is over. Every accepted request gets a registered response one cycle later, which carries read data and an error bit.

Top module: `regbank_guard`

## Requirements
- R1: A write to a legal word address other than 6 and 7 while the bank is locked sets status bit 0 (lock error), completes with resp_err=1 and changes no register.
- R2: A read of a word address of 8 or above sets status bit 1 (address error). This flag, marked as read-sourced, drives irq_rd_o.
- R3: A write to a word address of 8 or above sets status bit 1, marked as write-sourced, which drives irq_wr_o. The write completes with resp_err=1.
- R4: Enable register (address 1) bit 0 gates the lock flag and bit 1 gates the address flag. An interrupt line is high only when its flag and enable are both 1. It rises one cycle after the flag is set. A raw flag sets whatever its enable holds.
- R5: The fault-address register (address 2) captures the address of the first fault after reset or clear. Later faults leave it unchanged.
- R6: Together with the address, the kind register (address 3) captures 1 for a read-address fault, 2 for a write-address fault and 3 for a lock fault. The attribute register (address 4) captures the privilege bit at bit 8 and the 8-bit requester ID at bits 7:0.
- R7: A write with bit 0 = 1 to address 5 zeroes the fault address, kind and attribute registers and re-arms capture.
- R8: irq_any_o is the OR of irq_rd_o and irq_wr_o.
- R9: Status bit 2 reads 1 while locked. The bank opens only when a write of the first key to address 6 is followed, as the very next write, by a write of the second key to address 7. Any other value or order leaves it locked.
- R10: While the bank is open, a write of any value to address 6 or 7 locks it.
- R11: Status bits 0 and 1 clear when 1 is written to them. Writing 0 leaves them unchanged.
- R12: Every accepted request gets resp_valid one cycle later. A faulting read returns zero data. A legal access has resp_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_id | input | IDW | Requester ID sideband |
| req_priv | input | 1 | Privileged-access sideband |
| resp_valid | output | 1 | Response present |
| resp_rdata | output | DW | Read data |
| resp_err | output | 1 | Access was a violation |
| irq_rd_o | output | 1 | Read-error interrupt |
| irq_wr_o | output | 1 | Write-error interrupt |
| irq_any_o | output | 1 | Combined access-error interrupt |

## Verification
The properties assume a request holds for one cycle only when req_ready is high, and that req_addr and req_write are stable in that cycle. The bench drives each request for exactly one cycle on the falling edge and then leaves at least one idle cycle before the next. The random mix draws addresses from the decoded map and just past it. It also injects correct key pairs often enough that writes land on both the locked and the open bank. A bench model predicts the read data, the error bit and the three interrupt lines for every operation.

// File: rtl/regbank_guard_pkg.sv
package regbank_guard_pkg;

  typedef enum logic [1:0] {
    FK_NONE    = 2'b00,
    FK_RD_ADDR = 2'b01,
    FK_WR_ADDR = 2'b10,
    FK_LOCK    = 2'b11
  } fault_kind_e;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_st_e;

  localparam int REG_STAT  = 0;
  localparam int REG_IEN   = 1;
  localparam int REG_FADDR = 2;
  localparam int REG_FKIND = 3;
  localparam int REG_FATTR = 4;
  localparam int REG_FCLR  = 5;
  localparam int REG_KEY_A = 6;
  localparam int REG_KEY_B = 7;
  localparam int REG_COUNT = 8;

endpackage

// File: rtl/regbank_guard_decode.sv
module regbank_guard_decode
  import regbank_guard_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          fire,
  input  logic          is_write,
  input  logic [AW-1:0] addr,
  input  logic          locked,
  output logic          hit_stat,
  output logic          hit_ien,
  output logic          hit_fclr,
  output logic          hit_key_a,
  output logic          hit_key_b,
  output logic          wr_ok,
  output logic          ev_valid,
  output fault_kind_e   ev_kind
);

  logic [REG_COUNT-1:0] sel;
  logic                 legal;
  logic                 key_hit;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
    assign sel[i] = (addr == AW'(i));
  end

  assign legal   = |sel;
  assign key_hit = sel[REG_KEY_A] | sel[REG_KEY_B];

  always_comb begin
    ev_valid = 1'b0;
    ev_kind  = FK_NONE;
    if (fire) begin
      if (!legal) begin
        ev_valid = 1'b1;
        ev_kind  = is_write ? FK_WR_ADDR : FK_RD_ADDR;
      end else if (is_write && locked && !key_hit) begin
        ev_valid = 1'b1;
        ev_kind  = FK_LOCK;
      end
    end
  end

  assign wr_ok     = fire & is_write & legal & ~ev_valid;
  assign hit_stat  = sel[REG_STAT];
  assign hit_ien   = sel[REG_IEN];
  assign hit_fclr  = sel[REG_FCLR];
  assign hit_key_a = fire & is_write & sel[REG_KEY_A];
  assign hit_key_b = fire & is_write & sel[REG_KEY_B];

endmodule

// File: rtl/regbank_guard_lock.sv
module regbank_guard_lock
  import regbank_guard_pkg::*;
#(
  parameter int            DW    = 32,
  parameter logic [DW-1:0] KEY_A = 32'h5EED_C0DE,
  parameter logic [DW-1:0] KEY_B = 32'hA5C3_9E01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_any,
  input  logic          hit_a,
  input  logic          hit_b,
  input  logic [DW-1:0] wdata,
  output logic          locked
);

  lock_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LK_SHUT;
    end else if (wr_any) begin
      unique case (st_q)
        LK_SHUT: if (hit_a && wdata == KEY_A) st_q <= LK_HALF;
        LK_HALF: begin
          if (hit_b && wdata == KEY_B)      st_q <= LK_OPEN;
          else if (hit_a && wdata == KEY_A) st_q <= LK_HALF;
          else                              st_q <= LK_SHUT;
        end
        LK_OPEN: if (hit_a || hit_b) st_q <= LK_SHUT;
        default: st_q <= LK_SHUT;
      endcase
    end
  end

  assign locked = (st_q != LK_OPEN);

endmodule

// File: rtl/regbank_guard_capture.sv
module regbank_guard_capture
  import regbank_guard_pkg::*;
#(
  parameter int AW  = 6,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ev_valid,
  input  fault_kind_e    ev_kind,
  input  logic [AW-1:0]  ev_addr,
  input  logic [IDW-1:0] ev_id,
  input  logic           ev_priv,
  input  logic           clr,
  output logic           held,
  output logic [AW-1:0]  f_addr,
  output fault_kind_e    f_kind,
  output logic [IDW:0]   f_attr
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      held   <= 1'b0;
      f_addr <= '0;
      f_kind <= FK_NONE;
      f_attr <= '0;
    end else if (ev_valid && !held) begin
      held   <= 1'b1;
      f_addr <= ev_addr;
      f_kind <= ev_kind;
      f_attr <= {ev_priv, ev_id};
    end
  end

endmodule

// File: rtl/regbank_guard.sv
module regbank_guard
  import regbank_guard_pkg::*;
#(
  parameter int            AW    = 6,
  parameter int            DW    = 32,
  parameter int            IDW   = 8,
  parameter logic [DW-1:0] KEY_A = 32'h5EED_C0DE,
  parameter logic [DW-1:0] KEY_B = 32'hA5C3_9E01
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [IDW-1:0] req_id,
  input  logic           req_priv,
  output logic           resp_valid,
  output logic [DW-1:0]  resp_rdata,
  output logic           resp_err,
  output logic           irq_rd_o,
  output logic           irq_wr_o,
  output logic           irq_any_o
);

  logic        fire, locked;
  logic        hit_stat, hit_ien, hit_fclr, hit_key_a, hit_key_b, wr_ok;
  logic        ev_valid;
  fault_kind_e ev_kind;
  logic        cap_held;
  logic [AW-1:0] f_addr;
  fault_kind_e   f_kind;
  logic [IDW:0]  f_attr;
  logic        lock_raw, addr_raw, src_rd, src_wr;
  logic [1:0]  en_q;
  logic        fclr;
  logic [DW-1:0] rd_word;
  logic        irq_rd_n, irq_wr_n;

  assign fire = req_valid & req_ready;

  regbank_guard_decode #(.AW(AW)) u_decode (
    .fire(fire), .is_write(req_write), .addr(req_addr), .locked(locked),
    .hit_stat(hit_stat), .hit_ien(hit_ien), .hit_fclr(hit_fclr),
    .hit_key_a(hit_key_a), .hit_key_b(hit_key_b), .wr_ok(wr_ok),
    .ev_valid(ev_valid), .ev_kind(ev_kind)
  );

  regbank_guard_lock #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk(clk), .rst(rst), .wr_any(fire & req_write),
    .hit_a(hit_key_a), .hit_b(hit_key_b), .wdata(req_wdata), .locked(locked)
  );

  assign fclr = wr_ok & hit_fclr & req_wdata[0];

  regbank_guard_capture #(.AW(AW), .IDW(IDW)) u_capture (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_addr(req_addr), .ev_id(req_id), .ev_priv(req_priv), .clr(fclr),
    .held(cap_held), .f_addr(f_addr), .f_kind(f_kind), .f_attr(f_attr)
  );

  // raw flags: write-1-to-clear, a new event wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_raw <= 1'b0;
      addr_raw <= 1'b0;
      src_rd   <= 1'b0;
      src_wr   <= 1'b0;
      en_q     <= '0;
    end else begin
      if (wr_ok && hit_stat && req_wdata[0]) lock_raw <= 1'b0;
      if (wr_ok && hit_stat && req_wdata[1]) begin
        addr_raw <= 1'b0;
        src_rd   <= 1'b0;
        src_wr   <= 1'b0;
      end
      if (wr_ok && hit_ien) en_q <= req_wdata[1:0];
      if (ev_valid) begin
        unique case (ev_kind)
          FK_LOCK:    lock_raw <= 1'b1;
          FK_RD_ADDR: begin addr_raw <= 1'b1; src_rd <= 1'b1; end
          FK_WR_ADDR: begin addr_raw <= 1'b1; src_wr <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (req_addr)
      AW'(REG_STAT):  rd_word = DW'({locked, addr_raw, lock_raw});
      AW'(REG_IEN):   rd_word = DW'(en_q);
      AW'(REG_FADDR): rd_word = DW'(f_addr);
      AW'(REG_FKIND): rd_word = DW'(f_kind);
      AW'(REG_FATTR): rd_word = DW'(f_attr);
      default:        rd_word = '0;
    endcase
  end

  assign irq_rd_n = addr_raw & en_q[1] & src_rd;
  assign irq_wr_n = (lock_raw & en_q[0]) | (addr_raw & en_q[1] & src_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready  <= 1'b0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
      irq_rd_o   <= 1'b0;
      irq_wr_o   <= 1'b0;
      irq_any_o  <= 1'b0;
    end else begin
      req_ready  <= 1'b1;
      resp_valid <= fire;
      resp_err   <= ev_valid;
      resp_rdata <= (fire && !req_write && !ev_valid) ? rd_word : '0;
      irq_rd_o   <= irq_rd_n;
      irq_wr_o   <= irq_wr_n;
      irq_any_o  <= irq_rd_n | irq_wr_n;
    end
  end

endmodule

// File: rtl/regbank_guard_chk.sv
module regbank_guard_chk
  import regbank_guard_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          resp_valid,
  input logic          resp_err,
  input logic [DW-1:0] resp_rdata,
  input logic          irq_rd_o,
  input logic          irq_wr_o,
  input logic          irq_any_o,
  input logic          locked,
  input logic          held,
  input logic [AW-1:0] fault_addr,
  input logic [1:0]    en
);

  logic fire, bad_addr, key_addr, clr_req;
  assign fire     = req_valid && req_ready;
  assign bad_addr = req_addr >= AW'(REG_COUNT);
  assign key_addr = (req_addr == AW'(REG_KEY_A)) || (req_addr == AW'(REG_KEY_B));
  assign clr_req  = fire && req_write && req_addr == AW'(REG_FCLR) && req_wdata[0];

  // R12
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> resp_valid);

  // R12
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !req_write && bad_addr) |=> (resp_err && resp_rdata == '0));

  // R3
  bad_write_err_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write && bad_addr) |=> resp_err);

  // R1
  locked_en_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write && locked && req_addr == AW'(REG_IEN)) |=> $stable(en));

  // R5
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (held && !clr_req) |=> $stable(fault_addr));

  // R10
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write && !locked && key_addr) |=> locked);

  // R8
  any_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any_o == (irq_rd_o || irq_wr_o));

  // R4
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rd_o |-> $past(en[1]));

endmodule

bind regbank_guard regbank_guard_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
  .irq_rd_o(irq_rd_o), .irq_wr_o(irq_wr_o), .irq_any_o(irq_any_o),
  .locked(locked), .held(cap_held), .fault_addr(f_addr), .en(en_q)
);

// File: tb/regbank_guard_bench.sv
module regbank_guard_bench;

  localparam int            AW  = 6;
  localparam int            DW  = 32;
  localparam int            IDW = 8;
  localparam logic [DW-1:0] KA  = 32'h5EED_C0DE;
  localparam logic [DW-1:0] KB  = 32'hA5C3_9E01;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_write = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic [IDW-1:0] req_id = '0;
  logic           req_priv = 1'b0;
  logic           resp_valid;
  logic [DW-1:0]  resp_rdata;
  logic           resp_err;
  logic           irq_rd_o, irq_wr_o, irq_any_o;

  always #4 clk = ~clk;

  regbank_guard #(.AW(AW), .DW(DW), .IDW(IDW), .KEY_A(KA), .KEY_B(KB)) u_regbank_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_id(req_id), .req_priv(req_priv), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .resp_err(resp_err), .irq_rd_o(irq_rd_o),
    .irq_wr_o(irq_wr_o), .irq_any_o(irq_any_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model
  int            m_st = 0;          // 0 shut, 1 half, 2 open
  logic          m_lraw = 0, m_araw = 0, m_srd = 0, m_swr = 0;
  logic [1:0]    m_en = 0;
  logic          m_held = 0;
  logic [AW-1:0] m_fa = 0;
  logic [1:0]    m_fk = 0;
  logic [IDW:0]  m_fat = 0;
  logic [DW-1:0] last_rd;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_read(input int a);
    case (a)
      0: return DW'({m_st != 2, m_araw, m_lraw});
      1: return DW'(m_en);
      2: return DW'(m_fa);
      3: return DW'(m_fk);
      4: return DW'(m_fat);
      default: return '0;
    endcase
  endfunction

  task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d,
                       input logic [IDW-1:0] id, input bit pv);
    bit illegal = (a >= 8);
    bit lk = (m_st != 2);
    int kind = 0;
    string tag;
    logic [DW-1:0] exp_rd;
    if (illegal) kind = wr ? 2 : 1;
    else if (wr && lk && a != 6 && a != 7) kind = 3;
    tag = (kind == 3) ? "R1" : (kind == 1) ? "R2" : (kind == 2) ? "R3" : "R12";
    exp_rd = (!wr && kind == 0) ? model_read(a) : '0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a);
    req_wdata = d; req_id = id; req_priv = pv;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "resp_valid", DW'(resp_valid), DW'(1));
    chk(tag, "resp_err", DW'(resp_err), DW'(kind != 0));
    chk(tag, "resp_rdata", resp_rdata, exp_rd);
    last_rd = resp_rdata;

    if (wr) begin
      bit ka = !illegal && a == 6;
      bit kb = !illegal && a == 7;
      case (m_st)
        0: if (ka && d == KA) m_st = 1;
        1: if (kb && d == KB) m_st = 2; else if (ka && d == KA) m_st = 1; else m_st = 0;
        default: if (ka || kb) m_st = 0;
      endcase
      if (kind == 0) begin
        if (a == 0) begin
          if (d[0]) m_lraw = 0;
          if (d[1]) begin m_araw = 0; m_srd = 0; m_swr = 0; end
        end
        if (a == 1) m_en = d[1:0];
        if (a == 5 && d[0]) begin m_held = 0; m_fa = 0; m_fk = 0; m_fat = 0; end
      end
    end
    if (kind == 3) m_lraw = 1;
    if (kind == 1) begin m_araw = 1; m_srd = 1; end
    if (kind == 2) begin m_araw = 1; m_swr = 1; end
    if (kind != 0 && !m_held) begin
      m_held = 1; m_fa = AW'(a); m_fk = 2'(kind); m_fat = {pv, id};
    end

    @(negedge clk);
    begin
      logic erd = m_araw & m_en[1] & m_srd;
      logic ewr = (m_lraw & m_en[0]) | (m_araw & m_en[1] & m_swr);
      chk("R4", "irq_rd_o", DW'(irq_rd_o), DW'(erd));
      chk("R4", "irq_wr_o", DW'(irq_wr_o), DW'(ewr));
      chk("R8", "irq_any_o", DW'(irq_any_o), DW'(erd | ewr));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "reset resp_valid", DW'(resp_valid), 0);
    chk("R4", "reset irq_any", DW'(irq_any_o), 0);

    do_op(0, 0, 0, 0, 0);
    chk("R9", "status locked at reset", last_rd, 32'h4);

    // R1 lock violation on enable register
    do_op(1, 1, 32'h3, 8'h3C, 1);
    do_op(0, 1, 0, 0, 0);
    chk("R12", "enable unchanged by faulting write", last_rd, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R1", "status lock flag", last_rd, 32'h5);
    chk("R4", "irq_wr gated off", DW'(irq_wr_o), 0);
    do_op(0, 3, 0, 0, 0);
    chk("R6", "kind lock", last_rd, 32'h3);
    do_op(0, 2, 0, 0, 0);
    chk("R5", "fault addr", last_rd, 32'h1);
    do_op(0, 4, 0, 0, 0);
    chk("R6", "attr", last_rd, 32'h13C);

    // R2 illegal read, capture kept
    do_op(0, 9, 0, 8'h11, 0);
    chk("R2", "illegal read data", last_rd, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R2", "status addr flag", last_rd, 32'h7);
    do_op(0, 2, 0, 0, 0);
    chk("R5", "fault addr kept", last_rd, 32'h1);

    // R9 wrong sequences
    do_op(1, 6, KA, 0, 0);
    do_op(1, 7, KB ^ 32'h1, 0, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R9", "wrong second key stays locked", last_rd & 32'h4, 32'h4);
    do_op(1, 7, KB, 0, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R9", "out of order stays locked", last_rd & 32'h4, 32'h4);
    do_op(1, 6, KA, 0, 0);
    do_op(1, 7, KB, 0, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R9", "unlocked", last_rd & 32'h4, 0);

    do_op(1, 1, 32'h3, 0, 0);
    chk("R4", "irq_rd enabled", DW'(irq_rd_o), 1);
    chk("R4", "irq_wr enabled", DW'(irq_wr_o), 1);
    chk("R8", "irq_any", DW'(irq_any_o), 1);

    // R11 write-one-to-clear
    do_op(1, 0, 32'h0, 0, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R11", "zero write keeps flags", last_rd, 32'h3);
    do_op(1, 0, 32'h1, 0, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R11", "lock flag cleared", last_rd, 32'h2);
    chk("R4", "irq_wr after clear", DW'(irq_wr_o), 0);

    // R7 clear and re-arm
    do_op(1, 5, 32'h1, 0, 0);
    do_op(0, 2, 0, 0, 0);
    chk("R7", "fault addr cleared", last_rd, 0);
    do_op(0, 3, 0, 0, 0);
    chk("R7", "kind cleared", last_rd, 0);
    do_op(1, 12, 32'hDEAD, 8'h7E, 0);
    do_op(0, 3, 0, 0, 0);
    chk("R3", "kind write-address", last_rd, 32'h2);
    do_op(0, 2, 0, 0, 0);
    chk("R5", "recaptured addr", last_rd, 32'd12);
    chk("R3", "irq_wr from write-address flag", DW'(irq_wr_o), 1);

    // R10 relock
    do_op(1, 7, 32'h0, 0, 0);
    do_op(0, 0, 0, 0, 0);
    chk("R10", "relocked", last_rd & 32'h4, 32'h4);

    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 100;
      if (r < 12) begin
        do_op(1, 6, KA, 0, 0);
        do_op(1, 7, KB, 0, 0);
      end else begin
        int a = $urandom % 12;
        logic [DW-1:0] d = (a == 0 || a == 1 || a == 5) ? DW'($urandom % 4) : DW'($urandom);
        do_op(bit'($urandom % 2), a, d, IDW'($urandom), bit'($urandom % 2));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule